// File: doc/BRIEF.md
# FIFO Interrupt and Watermark Status Unit

This block sits next to a transmit FIFO and a receive FIFO of a serial flash controller and turns their occupancy counts and their push and pop strobes into one interrupt line. It keeps a seven-bit status vector. Four of its bits follow the live FIFO levels: transmit below watermark, transmit full, receive at or above watermark, and receive full. The other two are sticky error events: a push into a full receive FIFO, and a pop from an empty transmit FIFO.

Software reaches the unit through a small register port with a single-cycle write strobe and a combinational read. It can clear status bits by writing ones, and it can set or clear bits of the interrupt mask through two separate write-only addresses. It also programs the two watermarks. The interrupt output is high while any status bit is set whose mask bit is also set.

Top module: `fifo_irq_unit`

## Requirements
- R1: After reset the mask reads 0, the interrupt output is low and both watermarks read 1. With both FIFOs empty, status reads 0x04 once a clock edge has passed.
- R2: A write to offset 0x08 sets each mask bit whose data bit is one, and a write to offset 0x0C clears each mask bit whose data bit is one. Zero data bits leave the mask unchanged. The mask reads at offset 0x10, and offsets 0x08 and 0x0C read 0.
- R3: The interrupt output is high exactly when the status and the mask share at least one set bit.
- R4: A write to the status offset 0x04 clears every sticky bit whose data bit is one. A zero data bit leaves its status bit unchanged.
- R5: Status bit 0 is set on the clock edge that sees a receive push while the receive count equals the depth of 63. It then stays set until cleared, whatever the count does. A push at a lower count does not set it.
- R6: Status bit 6 is set on the clock edge that sees a transmit pop while the transmit count is 0. It is sticky in the same way. A pop at a non-zero count does not set it.
- R7: Status bit 2 reads 1 while the transmit count is below the transmit watermark at offset 0x28. A count equal to the watermark gives 0.
- R8: Status bit 3 reads 1 while the transmit count is 63, and status bit 5 reads 1 while the receive count is 63.
- R9: Status bit 4 reads 1 while the receive count is at least the larger of the receive watermark (offset 0x2C) and 1.
- R10: The level bits 2, 3, 4 and 5 follow their condition one clock edge later. A clearing write does not remove a level bit while its condition still holds.
- R11: The watermark registers keep the low 6 bits of written data and read back those bits with all higher bits 0.
- R12: Bit 1 and bits 7 and up of the status and the mask always read 0. The mask reads 0x7D after all ones are written to the set offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tx_count | input | 6 | Transmit FIFO occupancy |
| tx_pop | input | 1 | Transmit FIFO pop strobe |
| rx_count | input | 6 | Receive FIFO occupancy |
| rx_push | input | 1 | Receive FIFO push strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases are the interaction between a clearing write and a condition that is still present. A sticky overflow must survive the receive count falling from full. A level bit must come straight back after a clear while its FIFO stays full. The bench reaches these states by holding the count inputs at the depth, pulsing a push or a pop for one cycle, and then moving the counts. It reads the status before and after each clearing write. The floor of one entry on the receive watermark is checked by programming a watermark of zero with an empty receive FIFO.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
  localparam int IRQ_W = 7;

  localparam int B_RXOVF  = 0;
  localparam int B_TXLOW  = 2;
  localparam int B_TXFULL = 3;
  localparam int B_RXLVL  = 4;
  localparam int B_RXFULL = 5;
  localparam int B_TXUNF  = 6;

  localparam logic [IRQ_W-1:0] STICKY_BITS = 7'b100_0001;
  localparam logic [IRQ_W-1:0] LEVEL_BITS  = 7'b011_1100;
  localparam logic [IRQ_W-1:0] USED_BITS   = STICKY_BITS | LEVEL_BITS;

  localparam int OFF_STATUS = 'h04;
  localparam int OFF_SET    = 'h08;
  localparam int OFF_CLR    = 'h0C;
  localparam int OFF_MASK   = 'h10;
  localparam int OFF_TXWM   = 'h28;
  localparam int OFF_RXWM   = 'h2C;

  typedef struct packed {
    logic tx_low;
    logic tx_full;
    logic rx_lvl;
    logic rx_full;
  } lvl_t;

  typedef struct packed {
    logic rx_ovf;
    logic tx_unf;
  } evt_t;
endpackage

// File: rtl/fifo_irq_levels.sv
module fifo_irq_levels
  import fifo_irq_pkg::*;
#(
  parameter int DEPTH = 63,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] tx_count,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_wm,
  input  logic [CNT_W-1:0] rx_wm,
  input  logic             tx_pop,
  input  logic             rx_push,
  output lvl_t             lvl,
  output evt_t             evt
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  function automatic logic below_mark(input logic [CNT_W-1:0] cnt,
                                      input logic [CNT_W-1:0] wm);
    return cnt < wm;
  endfunction

  function automatic logic reaches_mark(input logic [CNT_W-1:0] cnt,
                                        input logic [CNT_W-1:0] wm);
    logic [CNT_W-1:0] floor_wm;
    floor_wm = (wm == '0) ? CNT_W'(1) : wm;
    return cnt >= floor_wm;
  endfunction

  function automatic logic is_full(input logic [CNT_W-1:0] cnt);
    return cnt >= FULL_CNT;
  endfunction

  always_comb begin
    lvl.tx_low  = below_mark(tx_count, tx_wm);
    lvl.tx_full = is_full(tx_count);
    lvl.rx_lvl  = reaches_mark(rx_count, rx_wm);
    lvl.rx_full = is_full(rx_count);
    evt.rx_ovf  = rx_push && is_full(rx_count);
    evt.tx_unf  = tx_pop && (tx_count == '0);
  end
endmodule

// File: rtl/fifo_irq_regs.sv
module fifo_irq_regs
  import fifo_irq_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [IRQ_W-1:0]  mask_q,
  output logic [CNT_W-1:0]  tx_wm_q,
  output logic [CNT_W-1:0]  rx_wm_q
);
  logic             set_hit, clr_hit, txwm_hit, rxwm_hit;
  logic [IRQ_W-1:0] wbits;

  assign set_hit  = reg_wr && (reg_addr == ADDR_W'(OFF_SET));
  assign clr_hit  = reg_wr && (reg_addr == ADDR_W'(OFF_CLR));
  assign txwm_hit = reg_wr && (reg_addr == ADDR_W'(OFF_TXWM));
  assign rxwm_hit = reg_wr && (reg_addr == ADDR_W'(OFF_RXWM));
  assign wbits    = reg_wdata[IRQ_W-1:0] & USED_BITS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      tx_wm_q <= CNT_W'(1);
      rx_wm_q <= CNT_W'(1);
    end else begin
      if (set_hit)  mask_q  <= mask_q | wbits;
      if (clr_hit)  mask_q  <= mask_q & ~wbits;
      if (txwm_hit) tx_wm_q <= reg_wdata[CNT_W-1:0];
      if (rxwm_hit) rx_wm_q <= reg_wdata[CNT_W-1:0];
    end
  end

  // R2: set offset raises every addressed mask bit
  p_mask_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_hit |=> ((mask_q & IRQ_W'($past(reg_wdata)) & USED_BITS)
                 == (IRQ_W'($past(reg_wdata)) & USED_BITS)));

  // R2: clear offset drops every addressed mask bit
  p_mask_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> ((mask_q & IRQ_W'($past(reg_wdata))) == '0));

  // R2: mask only moves on a set or clear write
  p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_hit || clr_hit) |=> $stable(mask_q));
endmodule

// File: rtl/fifo_irq_status.sv
module fifo_irq_status
  import fifo_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] set_vec,
  input  logic [IRQ_W-1:0] clr_vec,
  output logic [IRQ_W-1:0] status_q
);
  for (genvar i = 0; i < IRQ_W; i++) begin : g_bit
    if (STICKY_BITS[i]) begin : g_sticky
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q[i] <= 1'b0;
        else        status_q[i] <= set_vec[i] | (status_q[i] & ~clr_vec[i]);
      end

      // R4: a cleared sticky bit with no new event reads 0
      p_clr_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec[i] && !set_vec[i]) |=> !status_q[i]);

      // R4: without a clear a sticky bit never drops
      p_hold_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[i] && !clr_vec[i]) |=> status_q[i]);

      // R5 R6: an event always lands in the status
      p_event_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[i] |=> status_q[i]);
    end else if (LEVEL_BITS[i]) begin : g_level
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q[i] <= 1'b0;
        else        status_q[i] <= set_vec[i];
      end

      // R10: a clear does not remove a condition that still holds
      p_level_back_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec[i] && set_vec[i]) |=> status_q[i]);
    end else begin : g_unused
      assign status_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/fifo_irq_unit.sv
module fifo_irq_unit
  import fifo_irq_pkg::*;
#(
  parameter int DEPTH  = 63,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic              tx_pop,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic              rx_push,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  lvl_t             lvl;
  evt_t             evt;
  logic [IRQ_W-1:0] mask_q, status_q, set_vec, clr_vec;
  logic [CNT_W-1:0] tx_wm_q, rx_wm_q;
  logic             status_wr;

  fifo_irq_levels #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_levels (
    .tx_count(tx_count), .rx_count(rx_count),
    .tx_wm(tx_wm_q), .rx_wm(rx_wm_q),
    .tx_pop(tx_pop), .rx_push(rx_push),
    .lvl(lvl), .evt(evt)
  );

  fifo_irq_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .mask_q(mask_q), .tx_wm_q(tx_wm_q), .rx_wm_q(rx_wm_q)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[B_RXOVF]  = evt.rx_ovf;
    set_vec[B_TXLOW]  = lvl.tx_low;
    set_vec[B_TXFULL] = lvl.tx_full;
    set_vec[B_RXLVL]  = lvl.rx_lvl;
    set_vec[B_RXFULL] = lvl.rx_full;
    set_vec[B_TXUNF]  = evt.tx_unf;
  end

  assign status_wr = reg_wr && (reg_addr == ADDR_W'(OFF_STATUS));
  assign clr_vec   = status_wr ? reg_wdata[IRQ_W-1:0] : '0;

  fifo_irq_status u_status (
    .clk(clk), .rst_n(rst_n),
    .set_vec(set_vec), .clr_vec(clr_vec),
    .status_q(status_q)
  );

  function automatic logic [DATA_W-1:0] read_mux(
    input logic [ADDR_W-1:0] a, input logic [IRQ_W-1:0] st,
    input logic [IRQ_W-1:0] mk, input logic [CNT_W-1:0] twm,
    input logic [CNT_W-1:0] rwm);
    logic [DATA_W-1:0] r;
    r = '0;
    if (a == ADDR_W'(OFF_STATUS))    r = DATA_W'(st);
    else if (a == ADDR_W'(OFF_MASK)) r = DATA_W'(mk);
    else if (a == ADDR_W'(OFF_TXWM)) r = DATA_W'(twm);
    else if (a == ADDR_W'(OFF_RXWM)) r = DATA_W'(rwm);
    return r;
  endfunction

  assign reg_rdata = read_mux(reg_addr, status_q, mask_q, tx_wm_q, rx_wm_q);
  assign irq       = |(status_q & mask_q);

  // R3: an empty mask keeps the line low
  p_irq_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);

  // R3: a newly enabled pending bit raises the line
  p_irq_raise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(OFF_SET) && ((reg_wdata[IRQ_W-1:0] & status_q & set_vec & USED_BITS) != '0)) |=> irq);

  // R8: a full transmit FIFO shows in the status one edge later
  p_txfull_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == CNT_W'(DEPTH)) |=> status_q[B_TXFULL]);

  // R5: overflow from a push at the full count
  p_rxovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_count == CNT_W'(DEPTH)) |=> status_q[B_RXOVF]);

  // R6: underflow from a pop at zero
  p_txunf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pop && tx_count == '0) |=> status_q[B_TXUNF]);
endmodule

// File: tb/fifo_irq_unit_tb.sv
module fifo_irq_unit_tb;
  localparam int CNT_W = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] tx_count = '0;
  logic             tx_pop = 1'b0;
  logic [CNT_W-1:0] rx_count = '0;
  logic             rx_push = 1'b0;
  logic             reg_wr = 1'b0;
  logic [7:0]       reg_addr = '0;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      reg_rdata;
  logic             irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [31:0] exp_q[$];
  bit          kind_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  fifo_irq_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .tx_count(tx_count), .tx_pop(tx_pop),
    .rx_count(rx_count), .rx_push(rx_push),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  // monitor: compares queued expectations away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [31:0] e, got;
        bit k;
        string t;
        e = exp_q.pop_front();
        k = kind_q.pop_front();
        t = tag_q.pop_front();
        got = k ? {31'd0, irq} : reg_rdata;
        checks++;
        if (got !== e) begin
          errors++;
          $display("FAIL %s: got 0x%0h expected 0x%0h", t, got, e);
        end
      end
    end
  end

  task automatic wait_drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    reg_addr = a;
    exp_q.push_back(e); kind_q.push_back(1'b0); tag_q.push_back(t);
    wait_drain();
  endtask

  task automatic expect_irq(input logic e, input string t);
    @(negedge clk);
    exp_q.push_back({31'd0, e}); kind_q.push_back(1'b1); tag_q.push_back(t);
    wait_drain();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic counts(input int t, input int r);
    @(negedge clk);
    tx_count = CNT_W'(t); rx_count = CNT_W'(r);
  endtask

  task automatic pulse_push();
    @(negedge clk); rx_push = 1'b1;
    @(negedge clk); rx_push = 1'b0;
  endtask

  task automatic pulse_pop();
    @(negedge clk); tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        checks++; errors++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    expect_rd(8'h10, 32'h0, "R1 mask at reset");
    expect_irq(1'b0, "R1 irq at reset");
    expect_rd(8'h28, 32'h1, "R1 tx watermark at reset");
    expect_rd(8'h2C, 32'h1, "R1 rx watermark at reset");
    expect_rd(8'h04, 32'h04, "R1 R7 status empty fifos");

    wr(8'h08, 32'h04);
    expect_rd(8'h10, 32'h04, "R2 mask after set");
    expect_rd(8'h08, 32'h0, "R2 set offset reads 0");
    expect_rd(8'h0C, 32'h0, "R2 clear offset reads 0");
    expect_irq(1'b1, "R3 irq with tx low enabled");

    counts(10, 0);
    expect_rd(8'h04, 32'h00, "R7 tx count above watermark");
    expect_irq(1'b0, "R3 irq with nothing pending");
    wr(8'h28, 32'd11);
    expect_rd(8'h04, 32'h04, "R7 count below new watermark");
    wr(8'h28, 32'd10);
    expect_rd(8'h04, 32'h00, "R7 count equal to watermark");

    counts(63, 0);
    expect_rd(8'h04, 32'h08, "R8 tx full");
    counts(63, 62);
    pulse_push();
    expect_rd(8'h04, 32'h18, "R5 push below full no overflow");
    counts(63, 63);
    expect_rd(8'h04, 32'h38, "R8 rx full");
    pulse_push();
    expect_rd(8'h04, 32'h39, "R5 overflow set");
    counts(63, 5);
    expect_rd(8'h04, 32'h19, "R5 overflow sticky after drain");

    wr(8'h04, 32'h00);
    expect_rd(8'h04, 32'h19, "R4 zero write keeps status");
    wr(8'h04, 32'h01);
    expect_rd(8'h04, 32'h18, "R4 overflow cleared");
    wr(8'h04, 32'h18);
    expect_rd(8'h04, 32'h18, "R10 level bits back after clear");

    wr(8'h2C, 32'd6);
    expect_rd(8'h04, 32'h08, "R9 rx count below watermark");
    counts(63, 6);
    expect_rd(8'h04, 32'h18, "R9 rx count at watermark");
    wr(8'h2C, 32'd0);
    counts(63, 0);
    expect_rd(8'h04, 32'h08, "R9 zero watermark empty fifo");
    counts(63, 1);
    expect_rd(8'h04, 32'h18, "R9 zero watermark one entry");
    counts(5, 1);
    expect_rd(8'h04, 32'h14, "R10 level bit follows condition");

    counts(3, 1);
    pulse_pop();
    expect_rd(8'h04, 32'h14, "R6 pop at nonzero no underflow");
    counts(0, 1);
    pulse_pop();
    expect_rd(8'h04, 32'h54, "R6 underflow set");
    counts(2, 1);
    expect_rd(8'h04, 32'h54, "R6 underflow sticky");

    wr(8'h08, 32'h40);
    expect_rd(8'h10, 32'h44, "R2 second set keeps first bit");
    wr(8'h0C, 32'h04);
    expect_rd(8'h10, 32'h40, "R2 clear drops one bit");
    expect_irq(1'b1, "R3 irq from underflow");
    wr(8'h04, 32'h40);
    expect_rd(8'h04, 32'h14, "R4 underflow cleared");
    expect_irq(1'b0, "R3 irq after clear");

    wr(8'h08, 32'hFFFF_FFFF);
    expect_rd(8'h10, 32'h7D, "R12 mask unused bits zero");
    wr(8'h04, 32'hFFFF_FFFF);
    expect_rd(8'h04, 32'h14, "R12 status unused bits zero");

    wr(8'h28, 32'h45);
    expect_rd(8'h28, 32'h05, "R11 tx watermark truncated");
    wr(8'h2C, 32'hFFFF_FFFF);
    expect_rd(8'h2C, 32'h3F, "R11 rx watermark truncated");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule